// File: doc/BRIEF.md
# Gray-Pointer Method Submission Cache

This block takes method writes from a host and queues them in a small command cache, then hands them to a graphics engine. The host writes a 32-bit data word to an address inside a submission window. The block splits that address into a channel, a subchannel and a method word index, and stores all three with the data. The write-side and read-side pointers are held in Gray code. The read pointer register is exposed as a byte address of a 32-bit slot.

On the drain side, the block takes the head entry and uses its subchannel to pick one of eight context registers. If the chosen context carries the software-method mark, the entry is not passed to the engine. It is dropped from the cache in that cycle, and a sticky interrupt is raised so the host can service it. Every other entry is offered on a valid/ready output.

The output follows the usual stream rules. While `out_valid` is high and `out_ready` is low, the presented entry and its context do not change. The entry leaves the cache on the first clock edge where both are high. The host write side has no back-pressure: a write that finds the cache full is lost and is recorded in a sticky overflow bit.

Top module: `cmd_submit_fifo`

## Requirements
- R1: A write to word address `wr_addr` (byte address bits 22..2) is decoded as follows: channel = byte address bits 22..16, subchannel = bits 15..13, method word index = bits 12..2. The three fields and the data come back unchanged on `out_chan`, `out_sub`, `out_method` and `out_data` when that entry is presented.
- R2: Entries leave in the order they were written. The cache holds at most 31 entries: there are 32 slots, and one is always kept free.
- R3: While the access enable is clear, `wr_en` has no effect: nothing is stored, `put_ptr` does not move and `ovf` is not set. The enable is written through `en_we`/`en_val`.
- R4: `put_ptr` holds the Gray code (i XOR i>>1) of the next write slot index modulo 32. It advances once per accepted write.
- R5: `get_ptr` holds the Gray code of the next read slot index, shifted left by 2 bits. Its two low bits are always zero.
- R6: `out_ctx` is the context register whose index equals the head entry's subchannel. A context write through `ctx_we` takes effect from the next cycle.
- R7: If bit 23 of the selected context is set, the head entry is never presented (`out_valid` stays 0). It is removed at the next clock edge, and `sw_irq` is set at that same edge. `sw_irq` stays set until `irq_clr` is pulsed.
- R8: A write that finds the cache full, with access enabled, is dropped and sets `ovf`. `ovf` stays set until reset.
- R9: Once `out_valid` is high with `out_ready` low, the output stays valid and its content stays stable. The read pointer advances only on an edge where `out_valid` and `out_ready` are both high, or when an entry is diverted.
- R10: After reset, both pointers are zero, the access enable and all contexts are cleared, and `out_valid`, `sw_irq` and `ovf` are 0.
- R11: A write and an accepted read in the same cycle both take effect. Fullness is judged from the state before the edge, so a write to a full cache is dropped even if a read frees a slot in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host method write strobe |
| wr_addr | input | 21 | Word address within window (byte bits 22..2) |
| wr_data | input | 32 | Method data |
| en_we | input | 1 | Access enable write strobe |
| en_val | input | 1 | New access enable value |
| ctx_we | input | 1 | Context register write strobe |
| ctx_idx | input | 3 | Context register index |
| ctx_data | input | 32 | Context value |
| out_valid | output | 1 | Entry offered to the engine |
| out_ready | input | 1 | Engine accepts the entry |
| out_chan | output | 7 | Channel of the offered entry |
| out_sub | output | 3 | Subchannel of the offered entry |
| out_method | output | 11 | Method word index |
| out_data | output | 32 | Method data |
| out_ctx | output | 32 | Context selected by the head subchannel |
| sw_irq | output | 1 | Sticky software-method interrupt |
| irq_clr | input | 1 | Clears `sw_irq` |
| ovf | output | 1 | Sticky overflow status |
| put_ptr | output | 5 | Gray-coded write pointer |
| get_ptr | output | 7 | Gray-coded read pointer shifted left by 2 |

## Verification
Two events can share a clock edge: a host write and a read from the head. The bench sets up that overlap twice. In the first case the cache is full and `out_ready` is raised together with `wr_en`. The expected result is that the read pointer moves, while the write pointer and the stored contents do not. In the second case the cache holds one entry. The expected result is that both pointers step, and the newly written entry becomes the presented one in the following cycle.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int CH_W  = 7;
  localparam int SUB_W = 3;
  localparam int MW_W  = 11;
  localparam int DW    = 32;
  localparam int CTX_W = 32;
  localparam int AW    = 2 + MW_W + SUB_W + CH_W;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [SUB_W-1:0] sub;
    logic [MW_W-1:0]  mw;
    logic [DW-1:0]    data;
  } entry_t;
endpackage

// File: rtl/csf_gray_ptr.sv
module csf_gray_ptr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] gray_q,
  output logic [W-1:0] bin
);
  logic [W-1:0] nxt_bin;
  logic [W-1:0] nxt_gray;

  // fold the Gray value with shifted copies of itself
  always_comb begin
    bin = gray_q;
    for (int s = 1; s < W; s++) bin = bin ^ (gray_q >> s);
  end

  assign nxt_bin  = bin + 1'b1;
  assign nxt_gray = nxt_bin ^ (nxt_bin >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   gray_q <= '0;
    else if (adv) gray_q <= nxt_gray;
  end
endmodule

// File: rtl/csf_store.sv
module csf_store #(
  parameter int IW = 5,
  parameter int EW = 53
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/csf_ctx_bank.sv
module csf_ctx_bank #(
  parameter int XW = 3,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [XW-1:0] widx,
  input  logic [CW-1:0] wdata,
  input  logic [XW-1:0] ridx,
  output logic [CW-1:0] rdata
);
  localparam int N = 1 << XW;
  logic [CW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[widx] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/cmd_submit_fifo.sv
module cmd_submit_fifo
  import csf_pkg::*;
#(
  parameter int DEPTH_LOG = 5,
  parameter int SW_BIT    = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:2]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              en_we,
  input  logic              en_val,
  input  logic              ctx_we,
  input  logic [SUB_W-1:0]  ctx_idx,
  input  logic [CTX_W-1:0]  ctx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [SUB_W-1:0]  out_sub,
  output logic [MW_W-1:0]   out_method,
  output logic [DW-1:0]     out_data,
  output logic [CTX_W-1:0]  out_ctx,
  output logic              sw_irq,
  input  logic              irq_clr,
  output logic              ovf,
  output logic [DEPTH_LOG-1:0] put_ptr,
  output logic [DEPTH_LOG+1:0] get_ptr
);
  localparam int EW = $bits(entry_t);

  logic                 access_en;
  logic [DEPTH_LOG-1:0] put_gray, put_bin, get_gray, get_bin;
  logic [DEPTH_LOG-1:0] put_bin_nxt;
  logic                 full, empty, push_ok, sw_take, pop;
  entry_t               wr_ent, head;
  logic [EW-1:0]        head_raw;
  logic [CTX_W-1:0]     head_ctx;

  always_ff @(posedge clk) begin
    if (!rst_n)      access_en <= 1'b0;
    else if (en_we)  access_en <= en_val;
  end

  // address decode
  assign wr_ent.chan = wr_addr[AW-1 -: CH_W];
  assign wr_ent.sub  = wr_addr[2+MW_W +: SUB_W];
  assign wr_ent.mw   = wr_addr[2 +: MW_W];
  assign wr_ent.data = wr_data;

  assign put_bin_nxt = put_bin + 1'b1;
  assign empty   = (put_bin == get_bin);
  assign full    = (put_bin_nxt == get_bin);
  assign push_ok = wr_en && access_en && !full;

  csf_gray_ptr #(.W(DEPTH_LOG)) u_put (
    .clk(clk), .rst_n(rst_n), .adv(push_ok), .gray_q(put_gray), .bin(put_bin)
  );

  csf_gray_ptr #(.W(DEPTH_LOG)) u_get (
    .clk(clk), .rst_n(rst_n), .adv(pop), .gray_q(get_gray), .bin(get_bin)
  );

  csf_store #(.IW(DEPTH_LOG), .EW(EW)) u_store (
    .clk(clk), .we(push_ok), .waddr(put_bin), .wdata(wr_ent),
    .raddr(get_bin), .rdata(head_raw)
  );

  assign head = entry_t'(head_raw);

  csf_ctx_bank #(.XW(SUB_W), .CW(CTX_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .we(ctx_we), .widx(ctx_idx), .wdata(ctx_data),
    .ridx(head.sub), .rdata(head_ctx)
  );

  // pull side: divert software methods, otherwise offer to the engine
  assign sw_take   = !empty && head_ctx[SW_BIT];
  assign out_valid = !empty && !head_ctx[SW_BIT];
  assign pop       = sw_take || (out_valid && out_ready);

  assign out_chan   = head.chan;
  assign out_sub    = head.sub;
  assign out_method = head.mw;
  assign out_data   = head.data;
  assign out_ctx    = head_ctx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_irq <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (sw_take)      sw_irq <= 1'b1;
      else if (irq_clr) sw_irq <= 1'b0;
      if (wr_en && access_en && full) ovf <= 1'b1;
    end
  end

  assign put_ptr = put_gray;
  assign get_ptr = {get_gray, 2'b00};
endmodule

// File: rtl/csf_chk.sv
module csf_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          access_en,
  input logic          full,
  input logic [PW-1:0] put_ptr,
  input logic [PW+1:0] get_ptr,
  input logic          sw_take,
  input logic          sw_irq,
  input logic          ovf,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic [2:0]    out_sub,
  input logic          ctx_we
);
  p_ignore_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !access_en) |=> $stable(put_ptr));

  p_put_gray_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (put_ptr != $past(put_ptr)) |-> ($countones(put_ptr ^ $past(put_ptr)) == 1));

  p_get_gray_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (get_ptr != $past(get_ptr)) |-> ($countones(get_ptr ^ $past(get_ptr)) == 1));

  p_sw_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_take |=> sw_irq);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && access_en && full) |=> (ovf && $stable(put_ptr)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !ctx_we) |=>
      (out_valid && $stable(out_data) && $stable(out_sub) && $stable(get_ptr)));
endmodule

bind cmd_submit_fifo csf_chk #(.PW(DEPTH_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .access_en(access_en), .full(full),
  .put_ptr(put_ptr), .get_ptr(get_ptr), .sw_take(sw_take), .sw_irq(sw_irq),
  .ovf(ovf), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sub(out_sub), .ctx_we(ctx_we)
);

// File: tb/cmd_submit_fifo_test.sv
module cmd_submit_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        en_we = 1'b0, en_val = 1'b0;
  logic        ctx_we = 1'b0;
  logic [2:0]  ctx_idx = '0;
  logic [31:0] ctx_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [6:0]  out_chan;
  logic [2:0]  out_sub;
  logic [10:0] out_method;
  logic [31:0] out_data, out_ctx;
  logic        sw_irq, irq_clr = 1'b0, ovf;
  logic [4:0]  put_ptr;
  logic [6:0]  get_ptr;

  int errors = 0, checks = 0;
  int pc = 0, gc = 0;
  int m_chan [64], m_sub [64], m_mw [64];
  logic [31:0] m_data [64];
  logic [31:0] ctxv [8];

  always #2 clk = ~clk;

  cmd_submit_fifo uut (.*);

  function automatic int gray(int v);
    return (v % 32) ^ ((v % 32) >> 1);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int ch, int sb, int mw, logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = {ch[6:0], sb[2:0], mw[10:0]};
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctx(int i, logic [31:0] v);
    ctx_we = 1'b1; ctx_idx = i[2:0]; ctx_data = v; ctxv[i] = v;
    @(negedge clk);
    ctx_we = 1'b0;
  endtask

  task automatic model_push(int k);
    m_chan[pc % 64] = (k * 5) % 128;
    m_sub[pc % 64]  = k % 8;
    m_mw[pc % 64]   = (k * 37) % 2048;
    m_data[pc % 64] = (k * 32'h01010101) ^ 32'hA5;
    push(m_chan[pc % 64], m_sub[pc % 64], m_mw[pc % 64], m_data[pc % 64]);
    pc++;
  endtask

  task automatic check_head(string req);
    int s;
    s = gc % 64;
    chk(req, "valid", out_valid, 1);
    chk("R1", "chan", out_chan, m_chan[s]);
    chk("R1", "sub", out_sub, m_sub[s]);
    chk("R1", "method", out_method, m_mw[s]);
    chk("R2", "data", out_data, m_data[s]);
    chk("R6", "ctx", out_ctx, ctxv[m_sub[s]]);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) ctxv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "valid", out_valid, 0);
    chk("R10", "put", put_ptr, 0);
    chk("R10", "get", get_ptr, 0);
    chk("R10", "irq", sw_irq, 0);
    chk("R10", "ovf", ovf, 0);
    chk("R10", "ctx", out_ctx, 0);

    // R3 writes ignored while disabled
    push(1, 2, 3, 32'hDEAD);
    @(negedge clk);
    chk("R3", "put", put_ptr, 0);
    chk("R3", "valid", out_valid, 0);
    chk("R3", "ovf", ovf, 0);

    en_we = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_we = 1'b0;

    // R2/R4 fill to capacity
    for (int k = 0; k < 31; k++) begin
      model_push(k);
      chk("R4", "put", put_ptr, gray(pc));
    end
    check_head("R2");

    // R8 overflow on full
    push(9, 1, 1, 32'h1234);
    chk("R8", "ovf", ovf, 1);
    chk("R8", "put", put_ptr, gray(pc));

    // R11 write while full plus accepted read
    wr_en = 1'b1; wr_addr = 21'h1555; wr_data = 32'h5555; out_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; out_ready = 1'b0;
    gc++;
    chk("R11", "put", put_ptr, gray(pc));
    chk("R11", "get", get_ptr, gray(gc) << 2);

    // R9/R5 drain with stalls
    for (int k = 0; k < 30; k++) begin
      check_head("R9");
      @(negedge clk);
      check_head("R9");
      chk("R9", "get held", get_ptr, gray(gc) << 2);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      gc++;
      chk("R5", "get", get_ptr, gray(gc) << 2);
    end
    chk("R2", "empty", out_valid, 0);

    // R11 simultaneous write and read, pointer wrap
    model_push(40);
    check_head("R11");
    m_chan[pc % 64] = 3; m_sub[pc % 64] = 6; m_mw[pc % 64] = 2047; m_data[pc % 64] = 32'hCAFEF00D;
    wr_en = 1'b1; wr_addr = {7'd3, 3'd6, 11'd2047}; wr_data = 32'hCAFEF00D; out_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; out_ready = 1'b0;
    pc++; gc++;
    chk("R11", "put", put_ptr, gray(pc));
    chk("R11", "get", get_ptr, gray(gc) << 2);
    check_head("R11");
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0; gc++;

    // R6 context chosen by subchannel
    for (int i = 0; i < 8; i++) set_ctx(i, 32'h111 * (i + 1));
    for (int k = 0; k < 8; k++) begin
      model_push(k + 100);
      check_head("R6");
      out_ready = 1'b1; @(negedge clk); out_ready = 1'b0; gc++;
    end

    // R7 software-method diversion
    set_ctx(5, 32'h0080_0005);
    m_chan[pc % 64] = 1; m_sub[pc % 64] = 5; m_mw[pc % 64] = 7; m_data[pc % 64] = 32'h77;
    wr_en = 1'b1; wr_addr = {7'd1, 3'd5, 11'd7}; wr_data = 32'h77;
    @(negedge clk);
    pc++;
    m_chan[pc % 64] = 2; m_sub[pc % 64] = 2; m_mw[pc % 64] = 9; m_data[pc % 64] = 32'h99;
    wr_addr = {7'd2, 3'd2, 11'd9}; wr_data = 32'h99;
    chk("R7", "valid on sw head", out_valid, 0);
    chk("R7", "irq before", sw_irq, 0);
    @(negedge clk);
    wr_en = 1'b0;
    pc++; gc++;
    chk("R7", "irq", sw_irq, 1);
    chk("R7", "get", get_ptr, gray(gc) << 2);
    check_head("R7");
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R7", "irq clr", sw_irq, 0);
    chk("R8", "ovf sticky", ovf, 1);

    finish_run();
  end
endmodule